// File: doc/BRIEF.md
# Programmable-Tap Bit Scrambler and Descrambler

This block whitens a serial transmit bit stream and restores a serial receive bit stream. Both directions use a shift register of `LFSR_LEN` stages (7 by default). Which stages feed back is chosen at run time by a tap mask. The starting contents come from a programmable seed. One tap mask and one seed are shared by both directions.

Each direction has its own bit-valid strobe and its own load strobe. The load strobe presets that direction's register from the seed at the start of a packet. The transmit side feeds its own output back into its register. The receive side feeds the received line bit back instead. Because of this, the receive side locks onto any transmit stream after `LFSR_LEN` bits, whatever state it started in. A zero tap mask passes data through unchanged.

The scrambled or restored bit appears one clock after the input bit is accepted, together with an output-valid flag.

Top module: `scrambler_pair`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, both output-valid flags read 0 and both registers hold all zeros. A first bit sent with a non-zero tap mask then comes out equal to the input bit.
- R2: An output-valid flag is 1 exactly in the cycle after a cycle in which its bit-valid was 1 and its load was 0. It is 0 in every other cycle.
- R3: On the transmit side, an accepted bit produces output = input XOR parity(state AND taps). The register shifts left: bit 0 takes the output bit and bit k takes the old bit k-1.
- R4: On the receive side, an accepted bit produces output = input XOR parity(state AND taps). The register shifts left with bit 0 taking the received input bit, not the output.
- R5: Tap mask bit k selects register bit k, which is the bit accepted k+1 bits earlier. With mask 0x48 (stages of delay 4 and 7), a zero input gives output 1 for state 0x08 and for state 0x40, and output 0 for state 0x48 and for state 0x01.
- R6: A load presets that direction's register to the seed. When load and bit-valid are both 1 in the same cycle, load wins: the bit is dropped and no output is flagged.
- R7: In a cycle where bit-valid is 0, the register keeps its value. The output bit keeps its last value.
- R8: With a tap mask of zero, every output bit equals its input bit.
- R9: When the receive side is fed the transmit output, it returns the original data once `LFSR_LEN` bits have passed, even if the two registers started in different states. With equal starting states, it returns the data from the first bit.
- R10: The tap mask and the seed are shared by both directions: the same values apply to each side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| taps | input | LFSR_LEN | Feedback tap mask; bit k is the stage of delay k+1 |
| seed | input | LFSR_LEN | Preset value for both registers |
| tx_load | input | 1 | Preset the transmit register from seed |
| tx_valid | input | 1 | Transmit input bit is valid |
| tx_bit | input | 1 | Transmit input data bit |
| tx_out_valid | output | 1 | Scrambled bit is valid |
| tx_out_bit | output | 1 | Scrambled bit |
| rx_load | input | 1 | Preset the receive register from seed |
| rx_valid | input | 1 | Receive input bit is valid |
| rx_bit | input | 1 | Received line bit |
| rx_out_valid | output | 1 | Restored bit is valid |
| rx_out_bit | output | 1 | Restored bit |

## Verification
The bench builds the block with the default `LFSR_LEN` of 7. With seven stages, a 16-bit burst runs the whole register more than twice, so every tap position and the delay-7 stage reach the output within one burst. The hand-worked delay-4/delay-7 values can then be checked directly against the mask encoding. The same length keeps the receive lock-on window short, so a burst with unequal starting states shows both the garbled first seven bits and clean recovery afterwards.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic {
    MODE_SCRAMBLE   = 1'b0,
    MODE_DESCRAMBLE = 1'b1
  } lane_mode_e;

  // Choose which bit enters the shift register: the transmit side keeps its
  // own output, the receive side keeps the line bit.
  function automatic logic shift_source(input lane_mode_e mode,
                                        input logic line_bit,
                                        input logic mixed_bit);
    return (mode == MODE_DESCRAMBLE) ? line_bit : mixed_bit;
  endfunction

  // Combine an input bit with the feedback parity.
  function automatic logic mix_bit(input logic data_bit, input logic fb_bit);
    return data_bit ^ fb_bit;
  endfunction

endpackage

// File: rtl/scr_tap_parity.sv
module scr_tap_parity #(
  parameter int LEN = 7
) (
  input  logic [LEN-1:0] state,
  input  logic [LEN-1:0] taps,
  output logic           parity
);
  logic [LEN-1:0] masked;
  logic [LEN:0]   chain;

  assign masked   = state & taps;
  assign chain[0] = 1'b0;

  for (genvar k = 0; k < LEN; k++) begin : g_chain
    assign chain[k+1] = chain[k] ^ masked[k];
  end

  assign parity = chain[LEN];
endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
#(
  parameter int         LEN  = 7,
  parameter lane_mode_e MODE = MODE_SCRAMBLE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LEN-1:0] seed,
  input  logic           load,
  input  logic           advance,
  input  logic           in_bit,
  input  logic           fb,
  output logic [LEN-1:0] state_o,
  output logic           out_valid,
  output logic           out_bit
);
  logic [LEN-1:0] state_q;
  logic           mixed;
  logic           entering;

  assign mixed    = mix_bit(in_bit, fb);
  assign entering = shift_source(MODE, in_bit, mixed);
  assign state_o  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (load) begin
      state_q   <= seed;
      out_valid <= 1'b0;
    end else if (advance) begin
      state_q   <= {state_q[LEN-2:0], entering};
      out_valid <= 1'b1;
      out_bit   <= mixed;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scrambler_pair.sv
module scrambler_pair
  import scr_pkg::*;
#(
  parameter int LFSR_LEN = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LFSR_LEN-1:0] taps,
  input  logic [LFSR_LEN-1:0] seed,
  input  logic                tx_load,
  input  logic                tx_valid,
  input  logic                tx_bit,
  output logic                tx_out_valid,
  output logic                tx_out_bit,
  input  logic                rx_load,
  input  logic                rx_valid,
  input  logic                rx_bit,
  output logic                rx_out_valid,
  output logic                rx_out_bit
);
  // Named internal events, visible to the bound checker.
  logic [LFSR_LEN-1:0] tx_state, rx_state;
  logic                tx_fb, rx_fb;
  logic                tx_step, rx_step;

  assign tx_step = tx_valid & ~tx_load;
  assign rx_step = rx_valid & ~rx_load;

  scr_tap_parity #(.LEN(LFSR_LEN)) i_tx_par (
    .state(tx_state), .taps(taps), .parity(tx_fb)
  );
  scr_tap_parity #(.LEN(LFSR_LEN)) i_rx_par (
    .state(rx_state), .taps(taps), .parity(rx_fb)
  );

  scr_lane #(.LEN(LFSR_LEN), .MODE(MODE_SCRAMBLE)) i_tx_lane (
    .clk(clk), .rst_n(rst_n), .seed(seed), .load(tx_load),
    .advance(tx_step), .in_bit(tx_bit), .fb(tx_fb),
    .state_o(tx_state), .out_valid(tx_out_valid), .out_bit(tx_out_bit)
  );

  scr_lane #(.LEN(LFSR_LEN), .MODE(MODE_DESCRAMBLE)) i_rx_lane (
    .clk(clk), .rst_n(rst_n), .seed(seed), .load(rx_load),
    .advance(rx_step), .in_bit(rx_bit), .fb(rx_fb),
    .state_o(rx_state), .out_valid(rx_out_valid), .out_bit(rx_out_bit)
  );
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
  parameter int LEN = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [LEN-1:0] taps,
  input logic [LEN-1:0] seed,
  input logic           tx_load,
  input logic           tx_valid,
  input logic           tx_bit,
  input logic           tx_out_valid,
  input logic           tx_out_bit,
  input logic           rx_load,
  input logic           rx_valid,
  input logic           rx_bit,
  input logic           rx_out_valid,
  input logic           rx_out_bit,
  input logic [LEN-1:0] tx_state,
  input logic [LEN-1:0] rx_state,
  input logic           tx_fb,
  input logic           rx_fb
);
  // R2: output flagged exactly after an accepted bit
  a_r2_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_load) |=> tx_out_valid);
  a_r2_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && !rx_load) |=> !rx_out_valid);

  // R3: transmit register takes its own output into bit 0
  a_r3_tx_feeds_output: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_load) |=> (tx_state[0] == tx_out_bit)
      && (tx_state[LEN-1:1] == $past(tx_state[LEN-2:0])));

  // R4: receive register takes the line bit into bit 0
  a_r4_rx_feeds_line: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_load) |=> (rx_state[0] == $past(rx_bit))
      && (rx_out_bit == ($past(rx_bit) ^ $past(rx_fb))));

  // R6: load presets the register from the seed and suppresses output
  a_r6_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_state == $past(seed)) && !tx_out_valid);
  a_r6_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> (rx_state == $past(seed)) && !rx_out_valid);

  // R7: idle cycles keep state and output bit
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !tx_load) |=> $stable(tx_state) && $stable(tx_out_bit));

  // R8: zero mask passes data through
  a_r8_tx_zero_taps: assert property (@(posedge clk) disable iff (!rst_n)
    (taps == '0 && tx_valid && !tx_load) |=> (tx_out_bit == $past(tx_bit)));

  // R5: feedback is zero whenever no tapped stage is set
  a_r5_fb_untapped: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_state & taps) == '0) |-> !tx_fb);
endmodule

bind scrambler_pair scr_chk #(.LEN(LFSR_LEN)) i_chk (.*);

// File: tb/test_scrambler_pair.sv
module test_scrambler_pair;
  localparam int L = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] taps = '0, seed = '0;
  logic tx_load = 0, tx_valid = 0, tx_bit = 0;
  logic rx_load = 0, rx_valid = 0, rx_bit = 0;
  logic tx_out_valid, tx_out_bit, rx_out_valid, rx_out_bit;

  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  scrambler_pair #(.LFSR_LEN(L)) i_scrambler_pair (.*);

  // {taps, seed, 16 data bits}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {7'h48, 7'h7F, 16'hA5C3},
    {7'h48, 7'h01, 16'h0000},
    {7'h60, 7'h2A, 16'hFFFF},
    {7'h03, 7'h55, 16'h1234},
    {7'h7F, 7'h33, 16'hBEEF},
    {7'h11, 7'h00, 16'h8001}
  };

  // Bench model: the tapped-stage parity, worked out bit by bit.
  function automatic logic ref_par(input logic [L-1:0] st, input logic [L-1:0] tp);
    logic p = 1'b0;
    for (int k = 0; k < L; k++) if (tp[k]) p = p ^ st[k];
    return p;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, sample 1 ns later, return at negedge.
  task automatic cyc(input logic tv, input logic tb, input logic tl,
                     input logic rv, input logic rb, input logic rl);
    tx_valid = tv; tx_bit = tb; tx_load = tl;
    rx_valid = rv; rx_bit = rb; rx_load = rl;
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] ts, rs;
    logic o, s;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 tx_out_valid in reset", tx_out_valid, 1'b0);
    check("R1 rx_out_valid in reset", rx_out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx_out_valid after reset", tx_out_valid, 1'b0);
    taps = 7'h7F;
    cyc(1, 1, 0, 0, 0, 0);
    check("R1 zero state: first bit unscrambled", tx_out_bit, 1'b1);
    check("R2 valid flagged after accept", tx_out_valid, 1'b1);
    cyc(0, 0, 0, 0, 0, 0);
    check("R2 flag drops when idle", tx_out_valid, 1'b0);

    // Vector table: R3, R4, R9 (equal seeds), R10 (shared config)
    for (int v = 0; v < NV; v++) begin
      taps = VEC[v][29:23];
      seed = VEC[v][22:16];
      cyc(0, 0, 1, 0, 0, 1);
      ts = seed; rs = seed;
      for (int i = 0; i < 16; i++) begin
        o = VEC[v][i] ^ ref_par(ts, taps);
        ts = {ts[L-2:0], o};
        s = o ^ ref_par(rs, taps);
        rs = {rs[L-2:0], o};
        cyc(1, VEC[v][i], 0, 1, o, 0);
        check("R3 tx scrambled bit", tx_out_bit, o);
        check("R4 R10 rx restored bit", rx_out_bit, s);
        check("R9 rx equals data", rx_out_bit, VEC[v][i]);
      end
    end

    // R5: hand-worked delay-4/delay-7 mask
    taps = 7'h48;
    seed = 7'h08; cyc(0, 0, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
    check("R5 state 0x08 -> 1", tx_out_bit, 1'b1);
    seed = 7'h40; cyc(0, 0, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
    check("R5 state 0x40 -> 1", tx_out_bit, 1'b1);
    seed = 7'h48; cyc(0, 0, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
    check("R5 state 0x48 -> 0", tx_out_bit, 1'b0);
    seed = 7'h01; cyc(0, 0, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0);
    check("R5 state 0x01 -> 0", tx_out_bit, 1'b0);

    // R6: load wins over valid; bit dropped, state is seed
    seed = 7'h08; taps = 7'h08;
    cyc(1, 1, 1, 0, 0, 0);
    check("R6 load+valid: no output flag", tx_out_valid, 1'b0);
    cyc(1, 0, 0, 0, 0, 0);
    check("R6 state preset to seed", tx_out_bit, 1'b1);

    // R7: idle cycles keep state and output bit (state now 0x11, tap bit3 = 0)
    cyc(0, 1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    check("R7 output bit held", tx_out_bit, 1'b1);
    cyc(1, 0, 0, 0, 0, 0);
    check("R7 state unchanged across idle", tx_out_bit, 1'b0);

    // R8: zero mask passthrough
    taps = '0; seed = 7'h7F; cyc(0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      cyc(1, i[0] ^ i[1], 0, 1, i[1], 0);
      check("R8 tx passthrough", tx_out_bit, i[0] ^ i[1]);
      check("R8 rx passthrough", rx_out_bit, i[1]);
    end

    // R9: different starting states; rx locks after L bits
    taps = 7'h48;
    seed = 7'h5A; cyc(0, 0, 1, 0, 0, 0);
    seed = 7'h03; cyc(0, 0, 0, 0, 0, 1);
    ts = 7'h5A;
    for (int i = 0; i < 20; i++) begin
      logic d;
      d = (i % 3 == 0);
      o = d ^ ref_par(ts, taps);
      ts = {ts[L-2:0], o};
      cyc(1, d, 0, 1, o, 0);
      if (i >= L) check("R9 rx locked after L bits", rx_out_bit, d);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule